// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block makes the accept-or-drop decision for an incoming Ethernet frame before any storage or DMA work begins. The receive path presents the six destination address bytes and the frame length, together with a one-cycle valid strobe. One clock later the block raises exactly one of two one-cycle outputs: accept or drop.

Software programs the filter through a simple word-wide write port. There are five registers: two hold the station address, one holds the maximum frame length, one holds "drop" enables for group frames, and one holds "don't-care" overrides for group frames. The length check comes first. After that the destination is classed as broadcast, multicast or unicast. For a group frame (broadcast or multicast), the don't-care bit takes priority over the drop bit. A unicast frame passes only when it matches the station address exactly.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset, accept_o and drop_o are both low. The maximum length register reads as 0x0600, the don't-care register as 0x3FFFF, the drop register as 0, and the station address as all zeros.
- R2: One cycle after a cycle with frm_valid_i high, exactly one of accept_o and drop_o is high. When frm_valid_i was low in the previous cycle, both are low.
- R3: A frame whose length is greater than bits [15:0] of the maximum length register (write index 2) is dropped, whatever its destination. A length equal to that limit is not dropped by this check.
- R4: The station address is held in two registers. Write index 0 supplies bytes 1..4, with byte 1 in bits [31:24] and byte 4 in bits [7:0]. Write index 1 supplies byte 5 from bits [31:24] and byte 6 from bits [23:16]. Byte 1 is frm_dst_i[47:40], the first byte on the wire.
- R5: A destination of all ones is broadcast. The frame is accepted if bit 9 of the don't-care register (write index 4) is set. Otherwise it is dropped if bit 9 of the drop register (write index 3) is set. Otherwise it is accepted.
- R6: A destination that is not broadcast, but whose byte 1 has bit 0 set (frm_dst_i[40]), is multicast. It follows the same priority rule as R5, using bit 8 of each register.
- R7: Any other destination is accepted only if all six bytes equal the station address. Otherwise it is dropped.
- R8: A register write made in one cycle applies to a frame whose valid strobe arrives in the next cycle or later. A write to an index above 4 changes no filter decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_idx_i | input | 3 | Register index (0 and 1 are the station address, 2 is the maximum length, 3 is drop, 4 is don't-care) |
| cfg_wdata_i | input | 32 | Register write data |
| frm_valid_i | input | 1 | Frame descriptor valid |
| frm_dst_i | input | 48 | Destination address, byte 1 in [47:40] |
| frm_len_i | input | 16 | Frame length in bytes |
| accept_o | output | 1 | Frame accepted (one-cycle pulse) |
| drop_o | output | 1 | Frame dropped (one-cycle pulse) |

## Verification
A register write and a frame can arrive in the same cycle. The bench drives both together, for example by clearing the broadcast don't-care bit while a broadcast frame with its drop bit set is presented. It then checks that this frame is still judged by the old settings and that the next frame sees the new ones. Two rules can also apply to one frame at once: an oversize length together with a destination that would otherwise pass. The bench sweeps broadcast, multicast and unicast destinations against every combination of drop and don't-care bits, at lengths just below, at and above the limit. It expects drop whenever the length is over the limit.

// File: rtl/eth_rx_filt_pkg.sv
package eth_rx_filt_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * 8;
    localparam int LEN_W      = 16;
    localparam int REG_W      = 32;
    localparam int IDX_W      = 3;
    localparam int BCAST_BIT  = 9;
    localparam int MCAST_BIT  = 8;

    localparam logic [REG_W-1:0] MAXLEN_RST   = 32'h0000_0600;
    localparam logic [REG_W-1:0] DONTCARE_RST = 32'h0003_FFFF;
    localparam logic [REG_W-1:0] DROP_RST     = 32'h0000_0000;

    typedef enum logic [IDX_W-1:0] {
        IDX_STA_HI   = 3'd0,
        IDX_STA_LO   = 3'd1,
        IDX_MAXLEN   = 3'd2,
        IDX_DROP     = 3'd3,
        IDX_DONTCARE = 3'd4
    } reg_idx_e;

    typedef enum logic [1:0] {
        CLS_UNICAST = 2'd0,
        CLS_MCAST   = 2'd1,
        CLS_BCAST   = 2'd2
    } dst_class_e;

    typedef struct packed {
        logic [ADDR_W-1:0] station;
        logic [LEN_W-1:0]  max_len;
        logic              bc_drop;
        logic              mc_drop;
        logic              bc_dc;
        logic              mc_dc;
    } filt_cfg_t;

    function automatic dst_class_e classify(input logic [ADDR_W-1:0] dst);
        if (&dst)           return CLS_BCAST;
        else if (dst[ADDR_W-8]) return CLS_MCAST;
        else                return CLS_UNICAST;
    endfunction

    // Group frame rule: override wins over drop enable.
    function automatic logic group_pass(input logic dc, input logic drp);
        return dc | ~drp;
    endfunction
endpackage

// File: rtl/eth_rx_filt_regs.sv
module eth_rx_filt_regs
    import eth_rx_filt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wdata,
    output filt_cfg_t        cfg
);
    logic [REG_W-1:0] sta_hi_q, sta_lo_q, maxlen_q, drop_q, dc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sta_hi_q <= '0;
            sta_lo_q <= '0;
            maxlen_q <= MAXLEN_RST;
            drop_q   <= DROP_RST;
            dc_q     <= DONTCARE_RST;
        end else if (we) begin
            case (idx)
                IDX_STA_HI:   sta_hi_q <= wdata;
                IDX_STA_LO:   sta_lo_q <= wdata;
                IDX_MAXLEN:   maxlen_q <= wdata;
                IDX_DROP:     drop_q   <= wdata;
                IDX_DONTCARE: dc_q     <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg.station = {sta_hi_q, sta_lo_q[31:16]};
        cfg.max_len = maxlen_q[LEN_W-1:0];
        cfg.bc_drop = drop_q[BCAST_BIT];
        cfg.mc_drop = drop_q[MCAST_BIT];
        cfg.bc_dc   = dc_q[BCAST_BIT];
        cfg.mc_dc   = dc_q[MCAST_BIT];
    end
endmodule

// File: rtl/eth_rx_filt_match.sv
module eth_rx_filt_match
    import eth_rx_filt_pkg::*;
(
    input  logic [ADDR_W-1:0] dst,
    input  logic [ADDR_W-1:0] station,
    output logic              hit
);
    logic [ADDR_BYTES-1:0] byte_eq;
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
        assign byte_eq[g] = (dst[g*8 +: 8] == station[g*8 +: 8]);
    end
    assign hit = &byte_eq;
endmodule

// File: rtl/eth_rx_filt_decide.sv
module eth_rx_filt_decide
    import eth_rx_filt_pkg::*;
(
    input  logic [ADDR_W-1:0] dst,
    input  logic [LEN_W-1:0]  len,
    input  filt_cfg_t         cfg,
    output logic              pass
);
    dst_class_e cls;
    logic       uc_hit;
    logic       len_ok;

    eth_rx_filt_match u_match (
        .dst     (dst),
        .station (cfg.station),
        .hit     (uc_hit)
    );

    always_comb begin
        cls    = classify(dst);
        len_ok = (len <= cfg.max_len);
        if (!len_ok) pass = 1'b0;
        else begin
            unique case (cls)
                CLS_BCAST: pass = group_pass(cfg.bc_dc, cfg.bc_drop);
                CLS_MCAST: pass = group_pass(cfg.mc_dc, cfg.mc_drop);
                default:   pass = uc_hit;
            endcase
        end
    end
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
    import eth_rx_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we_i,
    input  logic [IDX_W-1:0]  cfg_idx_i,
    input  logic [REG_W-1:0]  cfg_wdata_i,
    input  logic              frm_valid_i,
    input  logic [ADDR_W-1:0] frm_dst_i,
    input  logic [LEN_W-1:0]  frm_len_i,
    output logic              accept_o,
    output logic              drop_o
);
    filt_cfg_t cfg;
    logic      pass;

    eth_rx_filt_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we_i),
        .idx   (cfg_idx_i),
        .wdata (cfg_wdata_i),
        .cfg   (cfg)
    );

    eth_rx_filt_decide u_decide (
        .dst  (frm_dst_i),
        .len  (frm_len_i),
        .cfg  (cfg),
        .pass (pass)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            accept_o <= 1'b0;
            drop_o   <= 1'b0;
        end else begin
            accept_o <= frm_valid_i & pass;
            drop_o   <= frm_valid_i & ~pass;
        end
    end
endmodule

// File: rtl/eth_rx_addr_filter_chk.sv
module eth_rx_addr_filter_chk
    import eth_rx_filt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frm_valid_i,
    input logic [ADDR_W-1:0] frm_dst_i,
    input logic [LEN_W-1:0]  frm_len_i,
    input logic              accept_o,
    input logic              drop_o,
    input filt_cfg_t         cfg
);
    p_one_hot_r2: assert property (@(posedge clk) disable iff (rst)
        frm_valid_i |=> (accept_o ^ drop_o));
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !frm_valid_i |=> (!accept_o && !drop_o));
    p_never_both_r2: assert property (@(posedge clk) disable iff (rst)
        !(accept_o && drop_o));
    p_oversize_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (frm_valid_i && frm_len_i > cfg.max_len) |=> drop_o);
    p_bcast_dc_r5: assert property (@(posedge clk) disable iff (rst)
        (frm_valid_i && (&frm_dst_i) && frm_len_i <= cfg.max_len && cfg.bc_dc) |=> accept_o);
    p_mcast_dc_r6: assert property (@(posedge clk) disable iff (rst)
        (frm_valid_i && !(&frm_dst_i) && frm_dst_i[40] && frm_len_i <= cfg.max_len && cfg.mc_dc) |=> accept_o);
    p_ucast_miss_r7: assert property (@(posedge clk) disable iff (rst)
        (frm_valid_i && !frm_dst_i[40] && frm_dst_i != cfg.station) |=> drop_o);
endmodule

bind eth_rx_addr_filter eth_rx_addr_filter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .frm_valid_i (frm_valid_i),
    .frm_dst_i   (frm_dst_i),
    .frm_len_i   (frm_len_i),
    .accept_o    (accept_o),
    .drop_o      (drop_o),
    .cfg         (cfg)
);

// File: tb/tb_eth_rx_addr_filter.sv
module tb_eth_rx_addr_filter;
    logic        clk = 0;
    logic        rst;
    logic        cfg_we_i;
    logic [2:0]  cfg_idx_i;
    logic [31:0] cfg_wdata_i;
    logic        frm_valid_i;
    logic [47:0] frm_dst_i;
    logic [15:0] frm_len_i;
    logic        accept_o, drop_o;

    int n_run = 0, n_fail = 0;
    logic [47:0] station;
    logic [15:0] maxlen;
    logic [31:0] drop_reg, dc_reg;

    always #2 clk = ~clk;

    eth_rx_addr_filter dut (.*);

    task automatic check(input string req, input logic acc, input logic drp,
                         input logic eacc, input logic edrp);
        n_run++;
        if (acc !== eacc || drp !== edrp) begin
            n_fail++;
            $display("FAIL %s: accept/drop=%b%b expected %b%b", req, acc, drp, eacc, edrp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we_i = 1; cfg_idx_i = idx; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 0;
        case (idx)
            3'd0: station[47:16] = d;
            3'd1: station[15:0]  = d[31:16];
            3'd2: maxlen = d[15:0];
            3'd3: drop_reg = d;
            3'd4: dc_reg = d;
            default: ;
        endcase
    endtask

    function automatic logic model(input logic [47:0] dst, input logic [15:0] len);
        if (len > maxlen) return 0;
        if (&dst) return dc_reg[9] | ~drop_reg[9];
        if (dst[40]) return dc_reg[8] | ~drop_reg[8];
        return dst == station;
    endfunction

    task automatic frame(input string req, input logic [47:0] dst, input logic [15:0] len);
        logic e;
        e = model(dst, len);
        @(negedge clk);
        frm_valid_i = 1; frm_dst_i = dst; frm_len_i = len;
        @(negedge clk);
        frm_valid_i = 0;
        check(req, accept_o, drop_o, e, ~e);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: accept/drop=%b%b expected done", accept_o, drop_o);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1; cfg_we_i = 0; cfg_idx_i = 0; cfg_wdata_i = 0;
        frm_valid_i = 0; frm_dst_i = 0; frm_len_i = 0;
        station = 0; maxlen = 16'h0600; drop_reg = 0; dc_reg = 32'h3FFFF;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset outputs and defaults
        check("R1", accept_o, drop_o, 0, 0);
        frame("R1", 48'hFFFF_FFFF_FFFF, 16'd64);
        frame("R1", 48'h0100_5E00_0001, 16'h0600);
        frame("R1", 48'h0, 16'h0600);
        frame("R1", 48'h0, 16'h0601);
        frame("R1", 48'h0000_0000_0001, 16'd60);
        // R2: idle gives nothing
        @(negedge clk);
        check("R2", accept_o, drop_o, 0, 0);
        // R4: station address byte mapping
        wr(3'd0, 32'h0211_2233);
        wr(3'd1, 32'h4455_ABCD);
        frame("R4", 48'h0211_2233_4455, 16'd100);
        frame("R4", 48'h0211_2233_4456, 16'd100);
        frame("R4", 48'h0211_2233_ABCD, 16'd100);
        // R7: each single byte mismatch
        for (int b = 0; b < 6; b++)
            frame("R7", 48'h0211_2233_4455 ^ (48'h2 << (b*8)), 16'd100);
        // R3: length boundaries
        wr(3'd2, 32'hFFFF_0040);
        frame("R3", 48'h0211_2233_4455, 16'h003F);
        frame("R3", 48'h0211_2233_4455, 16'h0040);
        frame("R3", 48'h0211_2233_4455, 16'h0041);
        frame("R3", 48'hFFFF_FFFF_FFFF, 16'h0041);
        // R5/R6 sweep: all drop/dc combinations, three lengths
        for (int c = 0; c < 16; c++) begin
            wr(3'd3, {22'd0, c[1], c[0], 8'd0});
            wr(3'd4, {22'd0, c[3], c[2], 8'd0});
            for (int l = 0; l < 3; l++) begin
                frame("R5", 48'hFFFF_FFFF_FFFF, 16'h003F + 16'(l));
                frame("R6", 48'h0100_5E00_00FB, 16'h003F + 16'(l));
                frame("R6", 48'hFFFF_FFFF_FFFE, 16'h003F + 16'(l));
                frame("R7", 48'h0211_2233_4455, 16'h003F + 16'(l));
                frame("R7", 48'h0000_0000_0000, 16'h003F + 16'(l));
            end
        end
        // R8: write in the same cycle as a frame uses old config
        wr(3'd3, 32'h0000_0200);
        wr(3'd4, 32'h0000_0200);
        @(negedge clk);
        cfg_we_i = 1; cfg_idx_i = 3'd4; cfg_wdata_i = 0;
        frm_valid_i = 1; frm_dst_i = 48'hFFFF_FFFF_FFFF; frm_len_i = 16'd10;
        @(negedge clk);
        cfg_we_i = 0; dc_reg = 0;
        check("R8", accept_o, drop_o, 1, 0);
        // next cycle frame sees new config
        frm_dst_i = 48'hFFFF_FFFF_FFFF;
        @(negedge clk);
        frm_valid_i = 0;
        check("R8", accept_o, drop_o, 0, 1);
        // R8: write to undefined index changes nothing
        wr(3'd7, 32'hFFFF_FFFF);
        wr(3'd5, 32'h0000_0000);
        frame("R8", 48'hFFFF_FFFF_FFFF, 16'd10);
        frame("R8", 48'h0211_2233_4455, 16'd10);
        frame("R8", 48'h0211_2233_4455, 16'h0041);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule